// File: doc/BRIEF.md
# Multi-Cycle Accumulator Processor Core

This block is a small processor core for an 8/16-bit accumulator instruction set. It runs one instruction at a time over a single byte-wide memory port. Each instruction is one opcode byte, and that byte alone sets the addressing mode and how many operand bytes follow. The supported subset covers these operations:

- loads into A, B, D (A:B), X, Y and SP
- stores from the same registers
- 8- and 16-bit add and subtract
- decrement of A
- an unconditional PC-relative branch
- a memory-to-memory byte copy

Sixteen-bit values are big-endian: the high byte sits at the effective address and the low byte at the next address.

The memory port is a plain synchronous interface with a 16-bit address, write data, a write strobe and read data. It has no handshake, so it never applies back-pressure. On every cycle the core drives an address. Read data must be valid in that same cycle. A write takes effect at the rising edge on which the strobe is high. The register file, the condition flags and a sticky illegal-opcode flag are brought out as ports for observation.

Top module: `acc_cpu`

## Requirements
- R1: While reset is asserted (active low, asynchronous), PC holds the `RESET_PC` parameter value. A, B, X, Y, SP, the flags and the illegal flag are all zero, and the write strobe is low.
- R2: The immediate loads are 0x86 (A, 1 byte), 0xC6 (B, 1 byte), 0xCC (D), 0xCE (X), 0xCD (Y) and 0xCF (SP). The 16-bit forms take two operand bytes, high byte first; for D, the high byte goes to A and the low byte to B.
- R3: Direct loads are 0x96 (A) and 0xD6 (B), and use the address 0x00nn. A direct load of A updates A on the third rising edge after reset is released: one edge each for the opcode, the operand and the data.
- R4: Extended loads are 0xB6 (A), 0xF6 (B) and 0xFC (D). The two address bytes come high first. A 16-bit load reads its high byte from the effective address and its low byte from the effective address plus one.
- R5: The stores are 0x5A (A, direct) and, in extended mode, 0x7A (A), 0x7B (B), 0x7C (D), 0x7E (X), 0x7D (Y) and 0x7F (SP). A 16-bit store writes the high byte to the effective address, then the low byte to the effective address plus one. Stores leave the flags unchanged, and only stores and moves raise the write strobe.
- R6: The arithmetic opcodes are 0x8B (A plus immediate), 0xBB (A plus extended), 0xCB (B plus immediate), 0xC3 (D plus 16-bit immediate), 0x80 (A minus immediate), 0xB0 (A minus extended) and 0xB3 (D minus the extended word). The flags output is {N,Z,V,C}. N is the result's sign bit and Z is set for a zero result. V is two's-complement overflow. C is the carry out for add and the borrow for subtract.
- R7: 0x43 decrements A with no operand. It updates N, Z and V (V is set only when A was 0x80) and leaves C unchanged.
- R8: Loads set N and Z from the loaded value and leave V and C unchanged.
- R9: 0x20 adds its sign-extended offset byte to the address of the byte after the two-byte branch. It changes no flag.
- R10: 0x0C copies one byte. Its four operand bytes are the source high, source low, destination high and destination low. It performs exactly one write, to the destination; the source, the registers and the flags are left as they were.
- R11: Any other opcode advances PC by one, sets the illegal flag and writes nothing. The illegal flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 16 | Memory address for the current cycle |
| mem_wdata | output | 8 | Byte to write |
| mem_we | output | 1 | Write strobe; the write happens at the rising edge |
| mem_rdata | input | 8 | Read data for `mem_addr`, valid in the same cycle |
| reg_a | output | 8 | Accumulator A |
| reg_b | output | 8 | Accumulator B |
| reg_x | output | 16 | Index register X |
| reg_y | output | 16 | Index register Y |
| reg_sp | output | 16 | Stack pointer |
| reg_pc | output | 16 | Program counter |
| ccr_nzvc | output | 4 | Flags {N,Z,V,C} |
| illegal_op | output | 1 | Sticky illegal-opcode flag |

## Verification
The assertions assume two things about the memory side. First, it answers every address in the same cycle with a defined byte. Second, it is the only thing that changes memory, and only on cycles when the core raises its strobe. The bench models memory as a combinational read with an edge-timed write and clears it before each program. Every program ends in a branch-to-self, so the core never runs off into unwritten bytes, except the one test that places an illegal opcode on purpose. Reset is held low while each program is loaded, so no assertion sees a partly loaded program.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int OPBUF_W = 4 * DW;

  typedef enum logic [2:0] {M_INH, M_IMM, M_DIR, M_EXT, M_REL, M_MOV} amode_e;
  typedef enum logic [2:0] {K_LD, K_ST, K_ADD, K_SUB, K_DEC, K_BRA, K_MOV} kind_e;
  typedef enum logic [2:0] {G_A, G_B, G_D, G_X, G_Y, G_S} greg_e;
  typedef enum logic [2:0] {S_FETCH, S_OPR, S_RD, S_WR, S_INH} state_e;

  typedef struct packed {
    logic   legal;
    amode_e mode;
    kind_e  kind;
    greg_e  dst;
    logic   wide;
  } dec_t;
endpackage

// File: rtl/acc_cpu_decode.sv
module acc_cpu_decode
  import acc_cpu_pkg::*;
(
  input  logic [DW-1:0] opcode,
  output dec_t          dec,
  output logic [2:0]    nops
);
  function automatic dec_t mk(amode_e m, kind_e k, greg_e g, logic w);
    mk = '{legal: 1'b1, mode: m, kind: k, dst: g, wide: w};
  endfunction

  always_comb begin
    case (opcode)
      8'h86: dec = mk(M_IMM, K_LD, G_A, 1'b0);
      8'h96: dec = mk(M_DIR, K_LD, G_A, 1'b0);
      8'hB6: dec = mk(M_EXT, K_LD, G_A, 1'b0);
      8'hC6: dec = mk(M_IMM, K_LD, G_B, 1'b0);
      8'hD6: dec = mk(M_DIR, K_LD, G_B, 1'b0);
      8'hF6: dec = mk(M_EXT, K_LD, G_B, 1'b0);
      8'hCC: dec = mk(M_IMM, K_LD, G_D, 1'b1);
      8'hFC: dec = mk(M_EXT, K_LD, G_D, 1'b1);
      8'hCE: dec = mk(M_IMM, K_LD, G_X, 1'b1);
      8'hCD: dec = mk(M_IMM, K_LD, G_Y, 1'b1);
      8'hCF: dec = mk(M_IMM, K_LD, G_S, 1'b1);
      8'h5A: dec = mk(M_DIR, K_ST, G_A, 1'b0);
      8'h7A: dec = mk(M_EXT, K_ST, G_A, 1'b0);
      8'h7B: dec = mk(M_EXT, K_ST, G_B, 1'b0);
      8'h7C: dec = mk(M_EXT, K_ST, G_D, 1'b1);
      8'h7E: dec = mk(M_EXT, K_ST, G_X, 1'b1);
      8'h7D: dec = mk(M_EXT, K_ST, G_Y, 1'b1);
      8'h7F: dec = mk(M_EXT, K_ST, G_S, 1'b1);
      8'h8B: dec = mk(M_IMM, K_ADD, G_A, 1'b0);
      8'hBB: dec = mk(M_EXT, K_ADD, G_A, 1'b0);
      8'hCB: dec = mk(M_IMM, K_ADD, G_B, 1'b0);
      8'hC3: dec = mk(M_IMM, K_ADD, G_D, 1'b1);
      8'h80: dec = mk(M_IMM, K_SUB, G_A, 1'b0);
      8'hB0: dec = mk(M_EXT, K_SUB, G_A, 1'b0);
      8'hB3: dec = mk(M_EXT, K_SUB, G_D, 1'b1);
      8'h43: dec = mk(M_INH, K_DEC, G_A, 1'b0);
      8'h20: dec = mk(M_REL, K_BRA, G_A, 1'b0);
      8'h0C: dec = mk(M_MOV, K_MOV, G_A, 1'b0);
      default: begin
        dec = mk(M_INH, K_BRA, G_A, 1'b0);
        dec.legal = 1'b0;
      end
    endcase
  end

  always_comb begin
    case (dec.mode)
      M_IMM:   nops = dec.wide ? 3'd2 : 3'd1;
      M_DIR:   nops = 3'd1;
      M_EXT:   nops = 3'd2;
      M_REL:   nops = 3'd1;
      M_MOV:   nops = 3'd4;
      default: nops = 3'd0;
    endcase
  end
endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
(
  input  kind_e           kind,
  input  logic            wide,
  input  logic [2*DW-1:0] lhs,
  input  logic [2*DW-1:0] rhs,
  output logic [2*DW-1:0] res,
  output logic            n_f,
  output logic            z_f,
  output logic            v_f,
  output logic            c_f,
  output logic            upd_v,
  output logic            upd_c
);
  localparam int WW = 2 * DW;

  logic [WW-1:0] l_op, r_op;
  logic [WW:0]   sum;
  logic          l_msb, r_msb, s_msb;

  always_comb begin
    l_op = wide ? lhs : {{DW{1'b0}}, lhs[DW-1:0]};
    r_op = wide ? rhs : {{DW{1'b0}}, rhs[DW-1:0]};
    case (kind)
      K_ADD:        sum = {1'b0, l_op} + {1'b0, r_op};
      K_SUB, K_DEC: sum = {1'b0, l_op} - {1'b0, r_op};
      default:      sum = {1'b0, r_op};
    endcase
    res   = wide ? sum[WW-1:0] : {{DW{1'b0}}, sum[DW-1:0]};
    l_msb = wide ? l_op[WW-1] : l_op[DW-1];
    r_msb = wide ? r_op[WW-1] : r_op[DW-1];
    s_msb = wide ? sum[WW-1]  : sum[DW-1];
    n_f   = s_msb;
    z_f   = (res == '0);
    c_f   = wide ? sum[WW] : sum[DW];
    if (kind == K_ADD) v_f = (l_msb == r_msb) && (s_msb != l_msb);
    else               v_f = (l_msb != r_msb) && (s_msb != l_msb);
    upd_v = (kind == K_ADD) || (kind == K_SUB) || (kind == K_DEC);
    upd_c = (kind == K_ADD) || (kind == K_SUB);
  end
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter logic [AW-1:0] RESET_PC = 16'h1000
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] reg_a,
  output logic [DW-1:0] reg_b,
  output logic [AW-1:0] reg_x,
  output logic [AW-1:0] reg_y,
  output logic [AW-1:0] reg_sp,
  output logic [AW-1:0] reg_pc,
  output logic [3:0]    ccr_nzvc,
  output logic          illegal_op
);
  localparam int WW = 2 * DW;

  state_e              state;
  logic [DW-1:0]       a, b, ir, prev;
  logic [AW-1:0]       x, y, sp, pc;
  logic [3:0]          ccr;
  logic                illegal;
  logic [OPBUF_W-1:0]  opbuf;
  logic [2:0]          cnt;

  dec_t                dec;
  logic [2:0]          nops;
  logic [WW-1:0]       sval, rhs, res;
  logic                n_f, z_f, v_f, c_f, upd_v, upd_c;
  logic                last, exec_now;
  logic [AW-1:0]       ea;

  acc_cpu_decode u_dec (
    .opcode (state == S_FETCH ? mem_rdata : ir),
    .dec    (dec),
    .nops   (nops)
  );

  always_comb begin
    case (dec.dst)
      G_A:     sval = {{DW{1'b0}}, a};
      G_B:     sval = {{DW{1'b0}}, b};
      G_D:     sval = {a, b};
      G_X:     sval = x;
      G_Y:     sval = y;
      default: sval = sp;
    endcase
  end

  assign rhs = (dec.kind == K_DEC) ? WW'(1) : {prev, mem_rdata};

  acc_cpu_alu u_alu (
    .kind  (dec.kind),
    .wide  (dec.wide),
    .lhs   (sval),
    .rhs   (rhs),
    .res   (res),
    .n_f   (n_f),
    .z_f   (z_f),
    .v_f   (v_f),
    .c_f   (c_f),
    .upd_v (upd_v),
    .upd_c (upd_c)
  );

  assign last = (cnt == nops - 3'd1);
  assign ea   = opbuf[AW-1:0] + {{(AW-3){1'b0}}, cnt};

  always_comb begin
    exec_now = 1'b0;
    case (state)
      S_OPR:   exec_now = last && (dec.mode == M_IMM);
      S_RD:    exec_now = (dec.mode != M_MOV) && (!dec.wide || cnt != 3'd0);
      S_INH:   exec_now = 1'b1;
      default: exec_now = 1'b0;
    endcase
  end

  always_comb begin
    case (state)
      S_RD:    mem_addr = (dec.kind == K_MOV) ? opbuf[OPBUF_W-1 -: AW] : ea;
      S_WR:    mem_addr = ea;
      default: mem_addr = pc;
    endcase
    mem_we = (state == S_WR);
    if (dec.kind == K_MOV)                mem_wdata = prev;
    else if (dec.wide && cnt == 3'd0)     mem_wdata = sval[WW-1:DW];
    else                                  mem_wdata = sval[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_FETCH;
      pc      <= RESET_PC;
      a       <= '0;
      b       <= '0;
      x       <= '0;
      y       <= '0;
      sp      <= '0;
      ccr     <= '0;
      illegal <= 1'b0;
      ir      <= '0;
      prev    <= '0;
      opbuf   <= '0;
      cnt     <= '0;
    end else begin
      if (exec_now) begin
        case (dec.dst)
          G_A:     a  <= res[DW-1:0];
          G_B:     b  <= res[DW-1:0];
          G_D:     begin a <= res[WW-1:DW]; b <= res[DW-1:0]; end
          G_X:     x  <= res;
          G_Y:     y  <= res;
          default: sp <= res;
        endcase
        ccr[3] <= n_f;
        ccr[2] <= z_f;
        if (upd_v) ccr[1] <= v_f;
        if (upd_c) ccr[0] <= c_f;
      end
      case (state)
        S_FETCH: begin
          ir    <= mem_rdata;
          pc    <= pc + AW'(1);
          opbuf <= '0;
          cnt   <= '0;
          if (!dec.legal)             illegal <= 1'b1;
          else if (dec.mode == M_INH) state   <= S_INH;
          else                        state   <= S_OPR;
        end
        S_OPR: begin
          pc    <= pc + AW'(1);
          opbuf <= {opbuf[OPBUF_W-DW-1:0], mem_rdata};
          prev  <= mem_rdata;
          cnt   <= cnt + 3'd1;
          if (last) begin
            cnt <= '0;
            case (dec.mode)
              M_REL: begin
                pc    <= pc + AW'(1) + {{(AW-DW){mem_rdata[DW-1]}}, mem_rdata};
                state <= S_FETCH;
              end
              M_IMM:   state <= S_FETCH;
              M_MOV:   state <= S_RD;
              default: state <= (dec.kind == K_ST) ? S_WR : S_RD;
            endcase
          end
        end
        S_RD: begin
          prev <= mem_rdata;
          if (dec.kind == K_MOV) begin
            cnt   <= '0;
            state <= S_WR;
          end else if (dec.wide && cnt == 3'd0) begin
            cnt <= 3'd1;
          end else begin
            state <= S_FETCH;
          end
        end
        S_WR: begin
          if (dec.wide && cnt == 3'd0 && dec.kind != K_MOV) cnt <= 3'd1;
          else                                              state <= S_FETCH;
        end
        default: state <= S_FETCH;
      endcase
    end
  end

  assign reg_a      = a;
  assign reg_b      = b;
  assign reg_x      = x;
  assign reg_y      = y;
  assign reg_sp     = sp;
  assign reg_pc     = pc;
  assign ccr_nzvc   = ccr;
  assign illegal_op = illegal;

  // R5: only store and move instructions drive the write strobe
  a_r5_we_only_store: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (dec.kind == K_ST || dec.kind == K_MOV));

  // R5: a store cycle leaves the flags as they were
  a_r5_store_flags: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> $stable(ccr));

  // R9: the branch leaves the flags as they were
  a_r9_bra_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_OPR && dec.mode == M_REL) |=> $stable(ccr));

  // R10: a move makes one write only
  a_r10_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && dec.kind == K_MOV) |=> !mem_we);

  // R11: an unknown opcode steps PC by one
  a_r11_illegal_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FETCH && !dec.legal) |=> (reg_pc == $past(reg_pc) + AW'(1)));

  // R11: the illegal flag is sticky
  a_r11_illegal_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |=> illegal_op);
endmodule

// File: tb/acc_cpu_test.sv
module acc_cpu_test;
  localparam logic [15:0] RST = 16'h0800;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we;
  logic [7:0]  mem_rdata;
  logic [7:0]  reg_a, reg_b;
  logic [15:0] reg_x, reg_y, reg_sp, reg_pc;
  logic [3:0]  ccr_nzvc;
  logic        illegal_op;

  logic [7:0]  mem [0:4095];
  logic [15:0] wp;
  int          checks = 0;
  int          fails = 0;
  int          cyc = 0;

  always #10 clk = ~clk;

  acc_cpu #(.RESET_PC(RST)) uut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .reg_a(reg_a), .reg_b(reg_b),
    .reg_x(reg_x), .reg_y(reg_y), .reg_sp(reg_sp), .reg_pc(reg_pc),
    .ccr_nzvc(ccr_nzvc), .illegal_op(illegal_op)
  );

  assign mem_rdata = mem[mem_addr[11:0]];
  always @(posedge clk) if (mem_we) mem[mem_addr[11:0]] = mem_wdata;

  // {opcode, initial A, operand, expected A, expected NZVC}
  localparam logic [35:0] VECS [0:10] = '{
    {8'h8B, 8'h7F, 8'h01, 8'h80, 4'hA},
    {8'h8B, 8'hFF, 8'h01, 8'h00, 4'h5},
    {8'h8B, 8'h10, 8'h22, 8'h32, 4'h0},
    {8'h80, 8'h00, 8'h01, 8'hFF, 4'h9},
    {8'h80, 8'h80, 8'h01, 8'h7F, 4'h2},
    {8'h80, 8'h05, 8'h05, 8'h00, 4'h4},
    {8'h43, 8'h80, 8'h00, 8'h7F, 4'h2},
    {8'h43, 8'h01, 8'h00, 8'h00, 4'h4},
    {8'h43, 8'h00, 8'h00, 8'hFF, 4'h8},
    {8'h86, 8'h33, 8'h00, 8'h00, 4'h4},
    {8'h86, 8'h33, 8'h9C, 8'h9C, 4'h8}
  };

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d cycles expected=fewer", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic start_prog();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    wp = RST;
  endtask

  task automatic emit(input logic [7:0] v);
    mem[wp[11:0]] = v;
    wp = wp + 16'd1;
  endtask

  task automatic put(input logic [15:0] ad, input logic [7:0] v);
    mem[ad[11:0]] = v;
  endtask

  task automatic boot(input int n);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 pc", 32'(reg_pc), 32'(RST));
    chk("R1 a b", 32'({reg_a, reg_b}), 32'h0);
    chk("R1 x y", {reg_x, reg_y}, 32'h0);
    chk("R1 sp", 32'(reg_sp), 32'h0);
    chk("R1 flags illegal", 32'({ccr_nzvc, illegal_op}), 32'h0);
    chk("R1 we", 32'(mem_we), 32'h0);

    // table of 8-bit arithmetic, decrement and load cases (R6, R7, R8)
    for (int k = 0; k < 11; k++) begin
      logic [35:0] v;
      string tag;
      v = VECS[k];
      tag = (v[35:28] == 8'h43) ? "R7" : (v[35:28] == 8'h86) ? "R8" : "R6";
      start_prog();
      emit(8'h86); emit(v[27:20]);
      emit(v[35:28]);
      if (v[35:28] != 8'h43) emit(v[19:12]);
      emit(8'h20); emit(8'hFE);
      boot(30);
      chk(tag, 32'(reg_a), 32'(v[11:4]));
      chk(tag, 32'(ccr_nzvc), 32'(v[3:0]));
    end

    // R3: direct load of A completes on the third edge
    start_prog();
    emit(8'h96); emit(8'h40); emit(8'h20); emit(8'hFE);
    put(16'h0040, 8'h5A);
    boot(2);
    chk("R3 before", 32'(reg_a), 32'h0);
    @(negedge clk);
    chk("R3 third edge", 32'(reg_a), 32'h5A);
    chk("R3 pc", 32'(reg_pc), 32'h0802);

    // R2: immediate loads, 8 and 16 bit
    start_prog();
    emit(8'hCC); emit(8'h12); emit(8'h34);
    emit(8'hCE); emit(8'hAB); emit(8'hCD);
    emit(8'hCD); emit(8'h01); emit(8'h02);
    emit(8'hCF); emit(8'h7F); emit(8'hFE);
    emit(8'hC6); emit(8'h9E);
    emit(8'h20); emit(8'hFE);
    boot(40);
    chk("R2 a b", 32'({reg_a, reg_b}), 32'h129E);
    chk("R2 x", 32'(reg_x), 32'hABCD);
    chk("R2 y", 32'(reg_y), 32'h0102);
    chk("R2 sp", 32'(reg_sp), 32'h7FFE);
    chk("R2 flags", 32'(ccr_nzvc), 32'h8);

    // R4 and R5: extended/direct loads and all stores
    start_prog();
    emit(8'hF6); emit(8'h0C); emit(8'h34);
    emit(8'h96); emit(8'h41);
    emit(8'h5A); emit(8'h60);
    emit(8'h7B); emit(8'h0C); emit(8'h61);
    emit(8'hCE); emit(8'hAB); emit(8'hCD);
    emit(8'h7E); emit(8'h0C); emit(8'h50);
    emit(8'hCD); emit(8'h01); emit(8'h02);
    emit(8'h7D); emit(8'h0C); emit(8'h54);
    emit(8'hCF); emit(8'h7F); emit(8'hFE);
    emit(8'h7F); emit(8'h0C); emit(8'h56);
    emit(8'hFC); emit(8'h0C); emit(8'h40);
    emit(8'h7C); emit(8'h0C); emit(8'h52);
    emit(8'h20); emit(8'hFE);
    put(16'h0C34, 8'hE1); put(16'h0041, 8'h6B);
    put(16'h0C40, 8'h80); put(16'h0C41, 8'h01);
    boot(120);
    chk("R4 d ext", 32'({reg_a, reg_b}), 32'h8001);
    chk("R5 staa dir", 32'(mem[12'h060]), 32'h6B);
    chk("R5 stab ext", 32'(mem[12'hC61]), 32'hE1);
    chk("R5 stx", 32'({mem[12'hC50], mem[12'hC51]}), 32'hABCD);
    chk("R5 sty", 32'({mem[12'hC54], mem[12'hC55]}), 32'h0102);
    chk("R5 sts", 32'({mem[12'hC56], mem[12'hC57]}), 32'h7FFE);
    chk("R5 std", 32'({mem[12'hC52], mem[12'hC53]}), 32'h8001);
    chk("R5 flags kept", 32'(ccr_nzvc), 32'h8);
    chk("R4 no stray write", 32'(mem[12'h0C3]), 32'h0);

    // R6: 16-bit and extended arithmetic
    start_prog();
    emit(8'hCC); emit(8'h80); emit(8'h01);
    emit(8'hB3); emit(8'h0C); emit(8'h70);
    emit(8'h7C); emit(8'h0C); emit(8'h74);
    emit(8'hC3); emit(8'h80); emit(8'h01);
    emit(8'h7C); emit(8'h0C); emit(8'h76);
    emit(8'hBB); emit(8'h0C); emit(8'h72);
    emit(8'h7A); emit(8'h0C); emit(8'h78);
    emit(8'hCB); emit(8'hFF);
    emit(8'hB0); emit(8'h0C); emit(8'h73);
    emit(8'h20); emit(8'hFE);
    put(16'h0C70, 8'h00); put(16'h0C71, 8'h02);
    put(16'h0C72, 8'h05); put(16'h0C73, 8'h06);
    put(16'h0C76, 8'hEE); put(16'h0C77, 8'hEE);
    boot(100);
    chk("R6 subd", 32'({mem[12'hC74], mem[12'hC75]}), 32'h7FFF);
    chk("R6 addd", 32'({mem[12'hC76], mem[12'hC77]}), 32'h0000);
    chk("R6 adda ext", 32'(mem[12'hC78]), 32'h05);
    chk("R6 a b", 32'({reg_a, reg_b}), 32'hFFFF);
    chk("R6 flags", 32'(ccr_nzvc), 32'h9);

    // R7: decrement keeps carry
    start_prog();
    emit(8'h86); emit(8'h00); emit(8'h80); emit(8'h01); emit(8'h43);
    emit(8'h20); emit(8'hFE);
    boot(30);
    chk("R7 a", 32'(reg_a), 32'hFE);
    chk("R7 carry kept", 32'(ccr_nzvc), 32'h9);

    // R8: load keeps V and C
    start_prog();
    emit(8'h86); emit(8'h00); emit(8'h80); emit(8'h80);
    emit(8'h86); emit(8'h05); emit(8'h20); emit(8'hFE);
    boot(30);
    chk("R8 a", 32'(reg_a), 32'h05);
    chk("R8 v c kept", 32'(ccr_nzvc), 32'h3);

    // R9: forward and backward branches
    start_prog();
    put(16'h0800, 8'h20); put(16'h0801, 8'h0E);
    put(16'h0802, 8'h86); put(16'h0803, 8'h11);
    put(16'h0810, 8'h86); put(16'h0811, 8'h77);
    put(16'h0812, 8'h20); put(16'h0813, 8'hF0);
    put(16'h0804, 8'h86); put(16'h0805, 8'h55);
    put(16'h0806, 8'h20); put(16'h0807, 8'hFE);
    boot(40);
    chk("R9 a", 32'(reg_a), 32'h55);
    chk("R9 loop pc", 32'(reg_pc == 16'h0806 || reg_pc == 16'h0807), 32'h1);
    chk("R9 no illegal", 32'(illegal_op), 32'h0);

    // R10: byte move
    start_prog();
    emit(8'h0C); emit(8'h0C); emit(8'h80); emit(8'h0C); emit(8'h90);
    emit(8'h20); emit(8'hFE);
    put(16'h0C80, 8'h3C);
    boot(30);
    chk("R10 dest", 32'(mem[12'hC90]), 32'h3C);
    chk("R10 source", 32'(mem[12'hC80]), 32'h3C);
    chk("R10 regs flags", 32'({reg_a, reg_b, ccr_nzvc}), 32'h0);
    chk("R10 next byte", 32'(mem[12'hC91]), 32'h0);

    // R11: illegal opcode
    start_prog();
    emit(8'h01); emit(8'h86); emit(8'h22); emit(8'h20); emit(8'hFE);
    boot(1);
    chk("R11 pc", 32'(reg_pc), 32'h0801);
    chk("R11 flag", 32'(illegal_op), 32'h1);
    repeat (10) @(negedge clk);
    chk("R11 continues", 32'(reg_a), 32'h22);
    chk("R11 sticky", 32'(illegal_op), 32'h1);

    summary();
    $finish;
  end
endmodule